// File: doc/BRIEF.md
# Address-Indexed Value Table

This block is a small tagged store that maps data addresses to data words. A load value predictor uses it for its second step. Once an earlier stage has produced a predicted load address, that address is presented on the lookup port. One cycle later the table reports whether it holds a word for that address, and if so, which word. A miss means that no value prediction is made for that load.

Two write ports keep the contents useful and correct. A prefetch-fill port installs words that were fetched ahead of time for future instances of a load. A store-commit port writes every committing store into the table, so that it never holds a word that memory has since replaced.

The table is direct-mapped. The byte offset of an address is ignored. The low word-address bits choose the entry, and the remaining upper bits are kept as the tag. Any write to an entry replaces whatever that entry held before.

Top module: `addr_value_table`

## Requirements
- R1: With the default parameters, address bits [1:0] are ignored, bits [7:2] select one of the 64 entries and bits [31:8] form the tag. A lookup hits only when the selected entry is valid and its tag equals the address tag.
- R2: The lookup result appears on `lk_hit`/`lk_data` at the clock edge after the request. It reflects the table contents before any write applied at that same edge.
- R3: A cycle without `lk_valid` gives `lk_hit` = 0 at the following edge.
- R4: Whenever `lk_hit` is 0, `lk_data` is all zeros.
- R5: A committing store always writes its word, tag and valid bit into the entry its address selects, whether or not the address hit. A later lookup of that address returns the store data.
- R6: A prefetch fill writes its word, tag and valid bit into the entry its address selects. A later lookup returns the fill data.
- R7: When a store and a fill select the same entry in one cycle, the store is written and the fill is discarded.
- R8: When a store and a fill select different entries in one cycle, both are written.
- R9: Reset clears every valid bit, so every lookup after reset misses until new writes arrive.
- R10: A write to an entry with a different tag evicts the previous address. A lookup of the evicted address then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Predicted load address |
| lk_hit | output | 1 | Registered hit flag |
| lk_data | output | DATA_W | Registered predicted value, zero on miss |
| st_valid | input | 1 | Store commit write |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| pf_valid | input | 1 | Prefetch fill write |
| pf_addr | input | ADDR_W | Fill address |
| pf_data | input | DATA_W | Fill data |

## Verification
Directed sequences cover several separate cases:
- Storing and looking up in the same cycle separates read-before-write from write-through.
- Re-reading an address with a different byte offset confirms that the offset is dropped.
- Addresses that share an index but differ in tag show that tags are compared and that old lines are evicted.
- Simultaneous store and fill, first to one entry and then to two entries, separate the priority rule from independent writes.

A long stream of random lookups, stores and fills over three tags per index, with random byte offsets, is then compared every cycle against a behavioural map of word addresses. This catches mistakes in the index or tag arithmetic that the directed cases could miss.

// File: rtl/avt_pkg.sv
package avt_pkg;

  localparam int AVT_ADDR_W     = 32;
  localparam int AVT_DATA_W     = 32;
  localparam int AVT_ENTRIES    = 64;
  localparam int AVT_WORD_BYTES = 4;

  // source selected for one entry's write in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_FILL  = 2'd2
  } wsrc_e;

  // entry number: drop the byte offset, keep idx_w low word bits
  function automatic logic [31:0] slot_of(input logic [63:0] addr,
                                          input int unsigned off_w,
                                          input int unsigned idx_w);
    logic [63:0] word;
    word = addr >> off_w;
    return word[31:0] & ((32'd1 << idx_w) - 32'd1);
  endfunction

  // tag: everything above offset and index
  function automatic logic [63:0] tag_of(input logic [63:0] addr,
                                         input int unsigned off_w,
                                         input int unsigned idx_w);
    return addr >> (off_w + idx_w);
  endfunction

endpackage

// File: rtl/avt_addr_split.sv
module avt_addr_split
  import avt_pkg::*;
#(
  parameter int ADDR_W     = AVT_ADDR_W,
  parameter int ENTRIES    = AVT_ENTRIES,
  parameter int WORD_BYTES = AVT_WORD_BYTES
) (
  input  logic [ADDR_W-1:0]                        addr,
  output logic [$clog2(ENTRIES)-1:0]               idx,
  output logic [ADDR_W-$clog2(WORD_BYTES)-$clog2(ENTRIES)-1:0] tag
);
  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [31:0] slot_full;
  logic [63:0] tag_full;

  always_comb begin
    slot_full = slot_of(64'(addr), OFF_W, IDX_W);
    tag_full  = tag_of(64'(addr), OFF_W, IDX_W);
    idx       = slot_full[IDX_W-1:0];
    tag       = tag_full[TAG_W-1:0];
  end
endmodule

// File: rtl/avt_write_arb.sv
module avt_write_arb
  import avt_pkg::*;
#(
  parameter int ENTRIES = AVT_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             st_valid,
  input  logic [IDX_W-1:0] st_idx,
  input  logic             pf_valid,
  input  logic [IDX_W-1:0] pf_idx,
  output logic             st_we,
  output logic             pf_we,
  output logic             fill_dropped,
  output wsrc_e            src [ENTRIES]
);
  always_comb begin
    st_we        = st_valid;
    fill_dropped = pf_valid && st_valid && (pf_idx == st_idx);
    pf_we        = pf_valid && !fill_dropped;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    always_comb begin
      if (st_we && st_idx == IDX_W'(i))      src[i] = SRC_STORE;
      else if (pf_we && pf_idx == IDX_W'(i)) src[i] = SRC_FILL;
      else                                   src[i] = SRC_NONE;
    end
  end
endmodule

// File: rtl/avt_entry_store.sv
module avt_entry_store
  import avt_pkg::*;
#(
  parameter int ENTRIES = AVT_ENTRIES,
  parameter int TAG_W   = 24,
  parameter int DATA_W  = AVT_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wsrc_e             src [ENTRIES],
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [DATA_W-1:0] st_data,
  input  logic [TAG_W-1:0]  pf_tag,
  input  logic [DATA_W-1:0] pf_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  // observation taps for the store/fill checks
  input  logic              st_we,
  input  logic              pf_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [IDX_W-1:0]  pf_idx
);
  logic [ENTRIES-1:0] ent_valid;
  logic [TAG_W-1:0]   ent_tag  [ENTRIES];
  logic [DATA_W-1:0]  ent_data [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                v_q <= 1'b0;
      else if (src[i] != SRC_NONE) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      case (src[i])
        SRC_STORE: begin t_q <= st_tag; d_q <= st_data; end
        SRC_FILL:  begin t_q <= pf_tag; d_q <= pf_data; end
        default:   ;
      endcase
    end

    assign ent_valid[i] = v_q;
    assign ent_tag[i]   = t_q;
    assign ent_data[i]  = d_q;
  end

  always_comb begin
    rd_valid = ent_valid[rd_idx];
    rd_tag   = ent_tag[rd_idx];
    rd_data  = ent_data[rd_idx];
  end

  // R5: a committed store is found in its entry at the next edge
  p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> ent_valid[$past(st_idx)] && ent_tag[$past(st_idx)] == $past(st_tag)
              && ent_data[$past(st_idx)] == $past(st_data));

  // R6: an accepted fill is found in its entry at the next edge
  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_we |=> ent_valid[$past(pf_idx)] && ent_data[$past(pf_idx)] == $past(pf_data));

  // R7: same-entry collision keeps the store data
  p_store_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && pf_idx == st_idx && $countones({st_we, pf_we}) == 1 && src[st_idx] == SRC_STORE)
    |=> ent_data[$past(st_idx)] == $past(st_data));

  // R9: the first edge after reset sees an empty table
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> ent_valid == '0);
endmodule

// File: rtl/avt_lookup_stage.sv
module avt_lookup_stage #(
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);
  logic tag_match;
  logic hit_now;

  always_comb begin
    tag_match = (rd_tag == lk_tag);
    hit_now   = lk_valid && rd_valid && tag_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_data <= '0;
    end else begin
      lk_hit  <= hit_now;
      lk_data <= hit_now ? rd_data : '0;
    end
  end

  // R3: no request, no hit
  p_idle_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit);

  // R4: a miss carries zero data
  p_miss_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_data == '0);

  // R1: a mismatching stored tag never yields a hit
  p_tag_mismatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && rd_tag != lk_tag) |=> !lk_hit);
endmodule

// File: rtl/addr_value_table.sv
module addr_value_table
  import avt_pkg::*;
#(
  parameter int ADDR_W     = AVT_ADDR_W,
  parameter int DATA_W     = AVT_DATA_W,
  parameter int ENTRIES    = AVT_ENTRIES,
  parameter int WORD_BYTES = AVT_WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic [DATA_W-1:0] pf_data
);
  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, st_idx, pf_idx;
  logic [TAG_W-1:0] lk_tag, st_tag, pf_tag;

  avt_addr_split #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .WORD_BYTES(WORD_BYTES))
    u_split_lk (.addr(lk_addr), .idx(lk_idx), .tag(lk_tag));
  avt_addr_split #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .WORD_BYTES(WORD_BYTES))
    u_split_st (.addr(st_addr), .idx(st_idx), .tag(st_tag));
  avt_addr_split #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .WORD_BYTES(WORD_BYTES))
    u_split_pf (.addr(pf_addr), .idx(pf_idx), .tag(pf_tag));

  logic  st_we, pf_we, fill_dropped;
  wsrc_e src [ENTRIES];

  avt_write_arb #(.ENTRIES(ENTRIES)) u_arb (
    .st_valid(st_valid), .st_idx(st_idx),
    .pf_valid(pf_valid), .pf_idx(pf_idx),
    .st_we(st_we), .pf_we(pf_we), .fill_dropped(fill_dropped), .src(src)
  );

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;

  avt_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .src(src),
    .st_tag(st_tag), .st_data(st_data), .pf_tag(pf_tag), .pf_data(pf_data),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .st_we(st_we), .pf_we(pf_we), .st_idx(st_idx), .pf_idx(pf_idx)
  );

  avt_lookup_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .lk_hit(lk_hit), .lk_data(lk_data)
  );

  // R7: a dropped fill always coincides with a store to the same entry
  p_drop_only_on_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_dropped |-> st_valid && pf_valid && st_idx == pf_idx);

  // R2: a hit is only ever reported for a request made one edge earlier
  p_hit_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));
endmodule

// File: tb/addr_value_table_test.sv
module addr_value_table_test;
  localparam int CLK_P = 10;
  localparam int ENT   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, st_valid = 1'b0, pf_valid = 1'b0;
  logic [31:0] lk_addr = '0, st_addr = '0, st_data = '0, pf_addr = '0, pf_data = '0;
  logic        lk_hit;
  logic [31:0] lk_data;

  always #(CLK_P/2) clk = ~clk;

  addr_value_table uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_data(pf_data)
  );

  // behavioural reference: word address -> word
  bit [31:0] ref_mem [int unsigned];
  bit        exp_hit;
  bit [31:0] exp_data;
  string     exp_tag = "R9";
  bit        armed = 1'b0;
  int        errs = 0, checks = 0;
  bit        done = 1'b0;

  task automatic model_write(input int unsigned w, input bit [31:0] d);
    int unsigned gone[$];
    foreach (ref_mem[k]) if ((k % ENT) == (w % ENT) && k != w) gone.push_back(k);
    foreach (gone[j]) ref_mem.delete(gone[j]);
    ref_mem[w] = d;
  endtask

  task automatic cyc(input bit lv, input bit [31:0] la,
                     input bit sv, input bit [31:0] sa, input bit [31:0] sd,
                     input bit pv, input bit [31:0] pa, input bit [31:0] pd,
                     input string tag);
    int unsigned w;
    @(negedge clk);
    if (armed) begin
      checks++;
      if (lk_hit !== exp_hit || lk_data !== exp_data) begin
        errs++;
        $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h",
                 exp_tag, lk_hit, lk_data, exp_hit, exp_data);
      end
    end
    w        = la >> 2;
    exp_hit  = lv && ref_mem.exists(w);
    exp_data = exp_hit ? ref_mem[w] : 32'd0;
    exp_tag  = tag;
    armed    = 1'b1;
    if (sv) model_write(sa >> 2, sd);
    if (pv && !(sv && ((sa >> 2) % ENT) == ((pa >> 2) % ENT))) model_write(pa >> 2, pd);
    lk_valid = lv; lk_addr = la;
    st_valid = sv; st_addr = sa; st_data = sd;
    pf_valid = pv; pf_addr = pa; pf_data = pd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lk_valid = 0; st_valid = 0; pf_valid = 0;
    ref_mem.delete();
    exp_hit = 0; exp_data = 0; exp_tag = "R9"; armed = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    cyc(1, 32'h100, 0, 0, 0, 0, 0, 0, "R9");                    // empty table misses
    cyc(1, 32'h100, 1, 32'h100, 32'hA1A1_0001, 0, 0, 0, "R2");  // read before same-edge write
    cyc(1, 32'h100, 0, 0, 0, 0, 0, 0, "R5");                    // store visible
    cyc(1, 32'h103, 0, 0, 0, 0, 0, 0, "R1");                    // byte offset ignored
    cyc(1, 32'h200, 0, 0, 0, 0, 0, 0, "R1");                    // same index, other tag
    cyc(0, 32'h100, 0, 0, 0, 1, 32'h204, 32'hB2B2_0002, "R3");  // idle request
    cyc(1, 32'h204, 0, 0, 0, 0, 0, 0, "R6");                    // fill visible
    cyc(1, 32'h101, 1, 32'h200, 32'hC3C3_0003, 0, 0, 0, "R2");  // old line still seen
    cyc(1, 32'h100, 0, 0, 0, 0, 0, 0, "R10");                   // evicted
    cyc(1, 32'h200, 0, 0, 0, 0, 0, 0, "R10");                   // new owner
    cyc(1, 32'h208, 1, 32'h300, 32'hD4D4_0004, 1, 32'h400, 32'hE5E5_0005, "R4");
    cyc(1, 32'h300, 0, 0, 0, 0, 0, 0, "R7");                    // store won
    cyc(1, 32'h400, 0, 0, 0, 0, 0, 0, "R7");                    // fill dropped
    cyc(0, 0, 1, 32'h108, 32'hF6F6_0006, 1, 32'h10C, 32'h0707_0007, "R3");
    cyc(1, 32'h108, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 32'h10E, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    do_reset();
    cyc(1, 32'h108, 0, 0, 0, 0, 0, 0, "R9");                    // cleared by reset
    cyc(1, 32'h300, 0, 0, 0, 0, 0, 0, "R9");
    for (int n = 0; n < 600; n++) begin
      bit [31:0] a0, a1, a2;
      a0 = (($urandom % 192) << 2) | ($urandom % 4);
      a1 = (($urandom % 192) << 2) | ($urandom % 4);
      a2 = (($urandom % 192) << 2) | ($urandom % 4);
      cyc($urandom % 4 != 0, a0,
          $urandom % 3 == 0, a1, $urandom,
          $urandom % 3 == 0, a2, $urandom, "R2");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule